// File: doc/BRIEF.md
# Dual-Space Bus Chip-Select Decoder

This block sits on a 16-bit processor bus that has one request strobe for memory cycles and a separate one for I/O cycles. For each access it raises at most one chip select. The possible targets are main RAM, a window of device registers at the top of memory, a port device decoded on the full address, and a port device decoded on a single address bit. The select outputs follow the bus combinationally within the cycle. Two registered bits sit beside them: a bank bit and a sticky protocol-error flag.

The top memory window is recognised from the two highest address bits alone. The bank bit chooses what that window reaches: the device registers, or the RAM that lies behind them. Software writes the bank bit through an I/O write to any odd port, taking the new value from a single data line. The bus must never carry both request strobes in one cycle. If it does, every select is held low and the error flag latches until the next reset.

Top module: `selx_bus_decoder`

## Requirements
- R1: A memory cycle (memory strobe high, I/O strobe low, read or write high) whose address bits 15 and 14 are both 1, while the bank bit is 1, raises only `win_cs`. Address bits 13..0 have no effect on this.
- R2: A memory cycle outside the top window, or inside it while the bank bit is 0, raises only `ram_cs`.
- R3: `ram_cs` is high only while the memory strobe is high and the I/O strobe is low. It is never high during an I/O cycle.
- R4: `port_full_cs` is high exactly when the I/O strobe is high, the memory strobe is low, the read strobe is high and the address equals 0x1234.
- R5: An I/O cycle (read or write) with address bit 0 equal to 0 raises `port_lazy_cs`, unless R4 matches. R4 takes priority over R5.
- R6: When both request strobes are high, all four selects are low. `proto_err` goes to 1 at the next clock edge and stays at 1 until reset.
- R7: An I/O write (I/O strobe high, memory strobe low, write high) with address bit 0 equal to 1 loads `wr_bit` into the bank bit at the clock edge. No other cycle changes the bank bit, and such a write raises no select. The current value is shown on `bank_dev`.
- R8: At most one select is high at any time. With neither strobe high, or with neither read nor write high, no select is high.
- R9: Reset (active-low, synchronous to the clock) sets `bank_dev` to 1 and `proto_err` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 16 | Processor address |
| mem_req | input | 1 | Memory request strobe |
| io_req | input | 1 | I/O request strobe |
| rd_stb | input | 1 | Read strobe |
| wr_stb | input | 1 | Write strobe |
| wr_bit | input | 1 | Data line sampled by a bank write |
| ram_cs | output | 1 | RAM chip select |
| win_cs | output | 1 | Top-window device register select |
| port_full_cs | output | 1 | Select for the port decoded on the full address |
| port_lazy_cs | output | 1 | Select for the port decoded on address bit 0 |
| bank_dev | output | 1 | Bank bit (1 = window reaches the devices) |
| proto_err | output | 1 | Sticky error flag for both strobes high |

## Verification
Address 0x1234 matches both port decoders. A write there must reach the bit-0 device, and a read must reach only the full-decode device; a design with the priority reversed or with the read qualifier dropped would raise two selects or the wrong one. The window is probed at 0xC000, 0xFFFF and a mid-window address with scattered low bits, and 0xBFFF is probed just below it, which exposes decoding on the wrong bits. The bank bit is cleared and set again through odd-port writes, and each time a window access is checked for RAM against device. A strobe clash is then driven with an odd-port write on the bus. A faulty design would let that cycle change the bank bit, raise a select, or fail to latch the error flag.

// File: rtl/selx_pkg.sv
package selx_pkg;

  // Decoded target of one bus cycle
  typedef enum logic [2:0] {
    TGT_NONE  = 3'd0,
    TGT_RAM   = 3'd1,
    TGT_WIN   = 3'd2,
    TGT_PFULL = 3'd3,
    TGT_PLAZY = 3'd4
  } selx_target_e;

  typedef struct packed {
    logic win;
    logic ram;
    logic pfull;
    logic plazy;
  } selx_sel_t;

  function automatic selx_sel_t selx_expand(input selx_target_e t);
    selx_sel_t s;
    s.win   = (t == TGT_WIN);
    s.ram   = (t == TGT_RAM);
    s.pfull = (t == TGT_PFULL);
    s.plazy = (t == TGT_PLAZY);
    return s;
  endfunction

endpackage

// File: rtl/selx_mem_dec.sv
module selx_mem_dec #(
  parameter int unsigned WIN_BITS = 2
) (
  input  logic [WIN_BITS-1:0] top_bits,
  input  logic                mem_cycle,
  input  logic                bank_dev,
  output selx_pkg::selx_target_e target
);
  import selx_pkg::*;

  // Lazy window test: only the top address bits are looked at
  function automatic logic in_window(input logic [WIN_BITS-1:0] b);
    return &b;
  endfunction

  logic win_hit;
  assign win_hit = in_window(top_bits);

  always_comb begin
    target = TGT_NONE;
    if (mem_cycle) begin
      if (win_hit && bank_dev) target = TGT_WIN;
      else                     target = TGT_RAM;
    end
  end

endmodule

// File: rtl/selx_io_dec.sv
module selx_io_dec #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] FULL_PORT = 16'h1234,
  parameter int unsigned LAZY_BIT  = 0,
  parameter logic        LAZY_LEVEL = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              io_cycle,
  input  logic              rd,
  output selx_pkg::selx_target_e target,
  output logic              lazy_match
);
  import selx_pkg::*;

  function automatic logic full_hit(input logic [ADDR_W-1:0] a);
    return a == FULL_PORT;
  endfunction

  function automatic logic lazy_hit(input logic [ADDR_W-1:0] a);
    return a[LAZY_BIT] == LAZY_LEVEL;
  endfunction

  logic full_match;
  assign full_match = io_cycle && rd && full_hit(addr);
  assign lazy_match = io_cycle && lazy_hit(addr);

  // Full decode wins over the single-bit decode
  always_comb begin
    target = TGT_NONE;
    if (full_match)      target = TGT_PFULL;
    else if (lazy_match) target = TGT_PLAZY;
  end

endmodule

// File: rtl/selx_ctrl.sv
module selx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clash,
  input  logic bank_wr,
  input  logic wr_bit,
  output logic bank_dev,
  output logic proto_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_dev  <= 1'b1;
      proto_err <= 1'b0;
    end else begin
      if (clash)   proto_err <= 1'b1;
      if (bank_wr) bank_dev  <= wr_bit;
    end
  end

  AST_ERR_SETS:   assert property (@(posedge clk) disable iff (!rst_n) clash |=> proto_err);          // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) proto_err |=> proto_err);      // R6
  AST_BANK_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !bank_wr |=> $stable(bank_dev)); // R7

endmodule

// File: rtl/selx_bus_decoder.sv
module selx_bus_decoder #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BITS  = 2,
  parameter logic [ADDR_W-1:0] FULL_PORT = 16'h1234,
  parameter int unsigned LAZY_BIT  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              mem_req,
  input  logic              io_req,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic              wr_bit,
  output logic              ram_cs,
  output logic              win_cs,
  output logic              port_full_cs,
  output logic              port_lazy_cs,
  output logic              bank_dev,
  output logic              proto_err
);
  import selx_pkg::*;

  localparam int unsigned TOP_LSB = ADDR_W - WIN_BITS;

  // Named events for the checks
  logic access, clash, mem_cycle, io_cycle, bank_wr, lazy_match;
  selx_target_e mem_tgt, io_tgt, final_tgt;
  selx_sel_t    sel;

  assign access    = rd_stb | wr_stb;
  assign clash     = mem_req & io_req;
  assign mem_cycle = mem_req & ~io_req & access;
  assign io_cycle  = io_req & ~mem_req & access;
  assign bank_wr   = io_req & ~mem_req & wr_stb & bus_addr[LAZY_BIT];

  selx_mem_dec #(.WIN_BITS(WIN_BITS)) u_mem (
    .top_bits (bus_addr[ADDR_W-1:TOP_LSB]),
    .mem_cycle(mem_cycle),
    .bank_dev (bank_dev),
    .target   (mem_tgt)
  );

  selx_io_dec #(
    .ADDR_W(ADDR_W), .FULL_PORT(FULL_PORT), .LAZY_BIT(LAZY_BIT), .LAZY_LEVEL(1'b0)
  ) u_io (
    .addr      (bus_addr),
    .io_cycle  (io_cycle),
    .rd        (rd_stb),
    .target    (io_tgt),
    .lazy_match(lazy_match)
  );

  selx_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clash    (clash),
    .bank_wr  (bank_wr),
    .wr_bit   (wr_bit),
    .bank_dev (bank_dev),
    .proto_err(proto_err)
  );

  always_comb begin
    if (clash)                  final_tgt = TGT_NONE;
    else if (mem_tgt != TGT_NONE) final_tgt = mem_tgt;
    else                        final_tgt = io_tgt;
  end

  assign sel          = selx_expand(final_tgt);
  assign ram_cs       = sel.ram;
  assign win_cs       = sel.win;
  assign port_full_cs = sel.pfull;
  assign port_lazy_cs = sel.plazy;

  AST_ONEHOT_SEL:   assert property (@(posedge clk) disable iff (!rst_n)
                      $onehot0({ram_cs, win_cs, port_full_cs, port_lazy_cs}));                 // R8
  AST_RAM_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
                      ram_cs |-> (mem_req && !io_req));                                        // R3
  AST_CLASH_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
                      clash |-> !(ram_cs || win_cs || port_full_cs || port_lazy_cs));          // R6
  AST_WIN_NO_RAM:   assert property (@(posedge clk) disable iff (!rst_n)
                      (mem_cycle && bank_dev && (&bus_addr[ADDR_W-1:TOP_LSB])) |-> (win_cs && !ram_cs)); // R1
  AST_FULL_BEATS_LAZY: assert property (@(posedge clk) disable iff (!rst_n)
                      (lazy_match && port_full_cs) |-> !port_lazy_cs);                         // R5
  AST_BANKWR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                      bank_wr |-> !(ram_cs || win_cs || port_full_cs || port_lazy_cs));        // R7

endmodule

// File: tb/sim_selx_bus_decoder.sv
module sim_selx_bus_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        mem_req = 0, io_req = 0, rd_stb = 0, wr_stb = 0, wr_bit = 0;
  logic        ram_cs, win_cs, port_full_cs, port_lazy_cs, bank_dev, proto_err;

  always #5 clk = ~clk;

  selx_bus_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .mem_req(mem_req), .io_req(io_req),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_bit(wr_bit), .ram_cs(ram_cs), .win_cs(win_cs),
    .port_full_cs(port_full_cs), .port_lazy_cs(port_lazy_cs), .bank_dev(bank_dev),
    .proto_err(proto_err)
  );

  typedef struct {
    logic [3:0] sel;   // {win, ram, full, lazy}
    logic       bank;
    logic       err;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   done = 0;
  logic bank_m = 1'b1, err_m = 1'b0;

  function automatic logic [3:0] expect_sel(logic [15:0] a, logic m, logic i,
                                            logic r, logic w, logic bk);
    if (!(r || w) || (m == i)) return 4'b0000;
    if (m) return (a[15] && a[14] && bk) ? 4'b1000 : 4'b0100;
    if (r && a == 16'h1234) return 4'b0010;
    if (a[0] == 1'b0) return 4'b0001;
    return 4'b0000;
  endfunction

  task automatic drive(logic [15:0] a, logic m, logic i, logic r, logic w,
                       logic wb, string tag);
    exp_t e;
    @(negedge clk);
    bus_addr = a; mem_req = m; io_req = i; rd_stb = r; wr_stb = w; wr_bit = wb;
    #2;
    e.sel = expect_sel(a, m, i, r, w, bank_m);
    e.bank = bank_m; e.err = err_m; e.tag = tag;
    q.push_back(e);
    if (m && i) err_m = 1'b1;
    else if (i && w && a[0]) bank_m = wb;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; mem_req = 0; io_req = 0; rd_stb = 0; wr_stb = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    bank_m = 1'b1; err_m = 1'b0;
  endtask

  // Monitor: pops expectations and compares
  initial begin
    forever begin
      exp_t e;
      logic [3:0] act;
      wait (q.size() > 0);
      e = q.pop_front();
      act = {win_cs, ram_cs, port_full_cs, port_lazy_cs};
      checks++;
      if (act !== e.sel || bank_dev !== e.bank || proto_err !== e.err) begin
        errors++;
        $display("FAIL %s: actual sel=%b bank=%b err=%b expected sel=%b bank=%b err=%b",
                 e.tag, act, bank_dev, proto_err, e.sel, e.bank, e.err);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    drive(16'h0000, 0, 0, 0, 0, 0, "R9 reset state idle");
    drive(16'h0000, 1, 0, 1, 0, 0, "R2 ram low address");
    drive(16'hBFFF, 1, 0, 0, 1, 0, "R2 ram just below window");
    drive(16'hC000, 1, 0, 1, 0, 0, "R1 window base");
    drive(16'hFFFF, 1, 0, 0, 1, 0, "R1 window top");
    drive(16'hD5A5, 1, 0, 1, 0, 0, "R1 low bits ignored");
    drive(16'h1234, 0, 1, 1, 0, 0, "R4 full port read");
    drive(16'h1234, 0, 1, 0, 1, 1, "R5 full port write goes lazy");
    drive(16'h1234, 1, 0, 1, 0, 0, "R3 same address in memory space is ram");
    drive(16'h00FE, 0, 1, 1, 0, 0, "R5 lazy port read");
    drive(16'h1236, 0, 1, 0, 1, 1, "R5 lazy port write");
    drive(16'h0000, 0, 1, 1, 0, 0, "R3 io cycle never ram");
    drive(16'h1235, 0, 1, 1, 0, 0, "R8 odd port read none");
    drive(16'hC000, 1, 0, 0, 0, 0, "R8 memory strobe without rd wr");
    drive(16'h00FF, 0, 1, 0, 1, 0, "R7 bank write 0 no select");
    drive(16'hC000, 1, 0, 1, 0, 0, "R7 window reaches ram bank 0");
    drive(16'hFFFF, 1, 0, 0, 1, 0, "R2 window top ram bank 0");
    drive(16'h0001, 1, 0, 0, 1, 1, "R7 memory write odd addr no bank change");
    drive(16'h0003, 0, 1, 1, 0, 1, "R7 io read odd no bank change");
    drive(16'h0101, 0, 1, 0, 1, 1, "R7 bank write 1");
    drive(16'hE000, 1, 0, 1, 0, 0, "R7 window back to devices");
    drive(16'h0001, 1, 1, 0, 1, 0, "R6 clash write quiet");
    drive(16'hC000, 1, 0, 1, 0, 0, "R6 error latched bank kept");
    drive(16'h1234, 0, 1, 1, 0, 0, "R6 error sticky");
    drive(16'h0000, 0, 0, 0, 0, 0, "R6 error still set idle");
    do_reset();
    drive(16'h0000, 0, 0, 0, 0, 0, "R9 reset clears error");
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule